// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a small synchronous static memory that acts as a slave on a processor or controller bus. The clock's rising edge captures the address, the write data, three chip-select inputs, two burst-start strobes, the burst-advance input and the write controls. Output enable and sleep act without waiting for a clock edge. The access address comes from one of two places. A start strobe loads the external address. After that, an internal 2-bit counter supplies the following addresses, stepping only in cycles where advance is asserted. The sequence of the two low address bits is either linear or interleaved. A caller that does not want bursts can present a new address with a start strobe on every cycle.

Reads are flow-through. The addressed word reaches the data output combinationally from the access address registered at the most recent edge, with no output register. Writes can be per-byte, using a byte-write enable with per-lane strobes, or whole-word, using a global write that overrides the byte controls.

Top module: `fts_burst_sram`

## Requirements
- R1: While reset is held, and after it is released, the block is deselected: `dq_drive` is 0 and `dout` is 0.
- R2: A start loads the address only when the chip selects sampled with it are {ce1_n,ce2,ce3_n} = 3'b010. A controller start with any other pattern deselects the chip. While deselected, `dq_drive` is 0, `dout` is 0 and no write happens.
- R3: When both start strobes are low, the processor start wins. A processor start with the chip not selected is ignored completely, and the access address and selection state do not change.
- R4: No cycle with `start_cpu_n` low writes the array, whatever the write controls are.
- R5: With no start and `adv_n` low while selected, the burst count steps by one and wraps modulo 4. With `adv_n` high the access address holds.
- R6: With `lin_order` = 0 (interleaved), the low two access-address bits are the start bits XOR the count. From start bits 1 the order is 1,0,3,2.
- R7: With `lin_order` = 1 (linear), the low two bits are the start bits plus the count, modulo 4. From start bits 1 the order is 1,2,3,0.
- R8: With `gwe_n` high and `bwe_n` low, lane i (bits [9i+8:9i]) is written exactly when `bstb_n[i]` is low. With `bwe_n` high, no lane is written.
- R9: With `gwe_n` low, every lane is written regardless of `bwe_n` and `bstb_n`.
- R10: `dout` shows the word at the access address of the most recent edge in that same cycle. This includes data written at that edge.
- R11: `oe_n` high drives `dq_drive` to 0 and `dout` to 0 at once, without a clock edge.
- R12: While `sleep` is high, `dq_drive` is 0 and no clocked state or array contents change. Operation resumes from the held state at the first edge after `sleep` falls.
- R13: Presenting a new address with a controller start on every cycle reads each address in the cycle it is given, with no penalty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | External word address |
| din | input | LANES*LANE_W | Write data |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| start_cpu_n | input | 1 | Processor-side burst start, active low |
| start_ctl_n | input | 1 | Controller-side burst start, active low |
| adv_n | input | 1 | Burst advance, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bstb_n | input | LANES | Per-lane write strobes, active low |
| gwe_n | input | 1 | Global write, active low |
| lin_order | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Low-power hold, active high, asynchronous |
| dout | output | LANES*LANE_W | Read data, 0 when not driven |
| dq_drive | output | 1 | High when the data output is actively driven |

## Verification
The embedded properties check on every cycle the following rules: the freeze during sleep, that an unselected processor start is ignored, the counter's step and hold behaviour, the deselect on a controller start, the absence of writes in processor-start or sleep cycles, and that global writes cover all lanes. Only the bench's scenarios can show whether the two burst orderings visit the right words and whether byte strobes merge the correct lanes. They also show that flow-through data appears in the same cycle, and that a write attempted while deselected, while asleep or under a processor start left the stored words unchanged.

// File: rtl/fts_pkg.sv
package fts_pkg;

  // Low two bits of the access address for a given start and count.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input logic       linear);
    logic [1:0] r;
    if (linear) r = start + cnt;
    else        r = start ^ cnt;
    return r;
  endfunction

  localparam logic [2:0] SEL_PATTERN = 3'b010;

endpackage

// File: rtl/fts_burst_seq.sv
module fts_burst_seq
  import fts_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        ce_vec,
  input  logic              start_cpu_n,
  input  logic              start_ctl_n,
  input  logic              adv_n,
  input  logic              lin_order,
  input  logic              sleep,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic              sel_q,
  output logic              sel_d
);

  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_q, cnt_d;
  logic              sel_ok;
  logic              upd_en;

  assign sel_ok = (ce_vec == SEL_PATTERN);
  assign upd_en = !sleep;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    sel_d  = sel_q;
    if (!start_cpu_n) begin
      if (sel_ok) begin
        base_d = addr;
        cnt_d  = 2'd0;
        sel_d  = 1'b1;
      end
    end else if (!start_ctl_n) begin
      if (sel_ok) begin
        base_d = addr;
        cnt_d  = 2'd0;
        sel_d  = 1'b1;
      end else begin
        sel_d  = 1'b0;
      end
    end else if (!adv_n && sel_q) begin
      cnt_d = cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
    end else if (upd_en) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      sel_q  <= sel_d;
    end
  end

  assign acc_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_q, lin_order)};
  assign nxt_addr = {base_d[ADDR_W-1:2], burst_low(base_d[1:0], cnt_d, lin_order)};

  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable({base_q, cnt_q, sel_q})) else $error("sleep freeze"); // R12

  AST_CPU_DESEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !start_cpu_n && ce_vec != SEL_PATTERN) |=> $stable({base_q, cnt_q, sel_q}))
    else $error("cpu start ignored"); // R3

  AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && start_cpu_n && start_ctl_n && !adv_n && sel_q) |=> (cnt_q == $past(cnt_q) + 2'd1))
    else $error("advance step"); // R5

  AST_NO_ADV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && start_cpu_n && start_ctl_n && adv_n) |=> $stable({base_q, cnt_q}))
    else $error("hold"); // R5

  AST_CTL_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && start_cpu_n && !start_ctl_n && ce_vec != SEL_PATTERN) |=> !sel_q)
    else $error("deselect"); // R2

endmodule

// File: rtl/fts_wr_lanes.sv
module fts_wr_lanes #(
  parameter int LANES = 2
) (
  input  logic             wr_ok,
  input  logic             gwe_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bstb_n,
  output logic [LANES-1:0] lane_we
);

  always_comb begin
    lane_we = '0;
    if (wr_ok) begin
      if (!gwe_n)      lane_we = '1;
      else if (!bwe_n) lane_we = ~bstb_n;
    end
  end

endmodule

// File: rtl/fts_lane_array.sv
module fts_lane_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        lane_we,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[g]) store[wr_addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = store[rd_addr];
  end

endmodule

// File: rtl/fts_burst_sram.sv
module fts_burst_sram
  import fts_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    start_cpu_n,
  input  logic                    start_ctl_n,
  input  logic                    adv_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bstb_n,
  input  logic                    gwe_n,
  input  logic                    lin_order,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dq_drive
);

  localparam int DATA_W = LANES * LANE_W;

  logic [1:0]        rsync_q;
  logic              rst_q;
  logic [ADDR_W-1:0] acc_addr, nxt_addr;
  logic              sel_q, sel_d;
  logic              wr_ok;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q = rsync_q[1];

  fts_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_q),
    .addr        (addr),
    .ce_vec      ({ce1_n, ce2, ce3_n}),
    .start_cpu_n (start_cpu_n),
    .start_ctl_n (start_ctl_n),
    .adv_n       (adv_n),
    .lin_order   (lin_order),
    .sleep       (sleep),
    .acc_addr    (acc_addr),
    .nxt_addr    (nxt_addr),
    .sel_q       (sel_q),
    .sel_d       (sel_d)
  );

  assign wr_ok = rst_q && !sleep && start_cpu_n && sel_d;

  fts_wr_lanes #(.LANES(LANES)) u_wr (
    .wr_ok   (wr_ok),
    .gwe_n   (gwe_n),
    .bwe_n   (bwe_n),
    .bstb_n  (bstb_n),
    .lane_we (lane_we)
  );

  fts_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk     (clk),
    .lane_we (lane_we),
    .wr_addr (nxt_addr),
    .wdata   (din),
    .rd_addr (acc_addr),
    .rdata   (rdata)
  );

  assign dq_drive = rst_q && sel_q && !oe_n && !sleep;
  assign dout     = dq_drive ? rdata : '0;

  AST_CPU_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_q)
    !start_cpu_n |-> (lane_we == '0)) else $error("cpu start wrote"); // R4

  AST_SLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_q)
    sleep |-> (lane_we == '0)) else $error("write in sleep"); // R12

  AST_GW_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_q)
    (!gwe_n && lane_we != '0) |-> (&lane_we)) else $error("global write partial"); // R9

endmodule

// File: tb/sim_fts_burst_sram.sv
`timescale 1ns/1ps
module sim_fts_burst_sram;

  localparam int AW = 8;
  localparam int DW = 18;
  localparam logic [2:0] S = 3'b010;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [2:0]    ce;
  logic          start_cpu_n, start_ctl_n, adv_n, bwe_n, gwe_n, lin_order, oe_n, sleep;
  logic [1:0]    bstb_n;
  logic [DW-1:0] dout;
  logic          dq_drive;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  fts_burst_sram u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .ce1_n(ce[2]), .ce2(ce[1]), .ce3_n(ce[0]),
    .start_cpu_n(start_cpu_n), .start_ctl_n(start_ctl_n), .adv_n(adv_n),
    .bwe_n(bwe_n), .bstb_n(bstb_n), .gwe_n(gwe_n), .lin_order(lin_order),
    .oe_n(oe_n), .sleep(sleep), .dout(dout), .dq_drive(dq_drive)
  );

  typedef logic [59:0] vec_t;

  function automatic vec_t v(input logic c_n, input logic t_n, input logic a_n,
                             input logic [2:0] cs, input logic g_n, input logic b_n,
                             input logic [1:0] st, input logic lin,
                             input logic [7:0] a, input logic [17:0] d,
                             input logic drv, input logic [17:0] ex, input logic [3:0] rq);
    return {c_n, t_n, a_n, cs, g_n, b_n, st, lin, a, d, drv, ex, rq};
  endfunction

  // fields: cpu_n ctl_n adv_n ce gw_n bwe_n bstb_n lin addr din | drive dout req
  localparam int NV = 30;
  localparam vec_t TBL [NV] = '{
    v(1,0,1,S,0,1,2'b11,0,8'h10,18'h00AAA, 1,18'h00AAA, 9),  // R9 load burst
    v(1,1,0,S,0,1,2'b11,0,8'h00,18'h00BBB, 1,18'h00BBB, 5),  // R5
    v(1,1,0,S,0,1,2'b11,0,8'h00,18'h00CCC, 1,18'h00CCC, 5),
    v(1,1,0,S,0,1,2'b11,0,8'h00,18'h00DDD, 1,18'h00DDD, 10), // R10
    v(1,0,1,S,1,1,2'b11,0,8'h11,18'h00000, 1,18'h00BBB, 13), // R13
    v(1,1,0,S,1,1,2'b11,0,8'h00,18'h00000, 1,18'h00AAA, 6),  // R6 interleaved 1,0,3,2
    v(1,1,0,S,1,1,2'b11,0,8'h00,18'h00000, 1,18'h00DDD, 6),
    v(1,1,0,S,1,1,2'b11,0,8'h00,18'h00000, 1,18'h00CCC, 6),
    v(1,1,0,S,1,1,2'b11,0,8'h00,18'h00000, 1,18'h00BBB, 5),  // R5 wrap
    v(1,0,1,S,1,1,2'b11,1,8'h11,18'h00000, 1,18'h00BBB, 7),  // R7 linear 1,2,3,0
    v(1,1,0,S,1,1,2'b11,1,8'h00,18'h00000, 1,18'h00CCC, 7),
    v(1,1,0,S,1,1,2'b11,1,8'h00,18'h00000, 1,18'h00DDD, 7),
    v(1,1,0,S,1,1,2'b11,1,8'h00,18'h00000, 1,18'h00AAA, 7),
    v(1,1,1,S,1,1,2'b11,1,8'h00,18'h00000, 1,18'h00AAA, 5),  // R5 hold
    v(1,0,1,S,1,0,2'b10,0,8'h13,18'h3FFFF, 1,18'h00DFF, 8),  // R8 lane 0 only
    v(1,1,1,S,1,0,2'b11,0,8'h00,18'h00000, 1,18'h00DFF, 8),  // R8 no strobe
    v(1,1,1,S,1,1,2'b00,0,8'h00,18'h00000, 1,18'h00DFF, 8),  // R8 enable off
    v(1,1,1,S,1,0,2'b01,0,8'h00,18'h3FFFF, 1,18'h3FFFF, 8),  // R8 lane 1 only
    v(1,1,1,S,0,1,2'b11,0,8'h00,18'h01234, 1,18'h01234, 9),  // R9
    v(1,1,1,S,0,0,2'b10,0,8'h00,18'h00567, 1,18'h00567, 9),  // R9 override
    v(0,1,1,S,0,1,2'b11,0,8'h10,18'h12345, 1,18'h00AAA, 4),  // R4
    v(1,1,0,S,0,1,2'b11,0,8'h00,18'h12345, 1,18'h12345, 4),
    v(0,1,1,3'b110,1,1,2'b11,0,8'h30,18'h00000, 1,18'h12345, 3), // R3
    v(0,0,1,3'b000,1,1,2'b11,0,8'h30,18'h00000, 1,18'h12345, 3),
    v(0,0,1,S,0,1,2'b11,0,8'h12,18'h3AAAA, 1,18'h00CCC, 3),  // R3 cpu wins, no write
    v(1,0,1,3'b011,1,1,2'b11,0,8'h20,18'h00000, 0,18'h00000, 2), // R2
    v(1,1,0,S,0,1,2'b11,0,8'h00,18'h15555, 0,18'h00000, 2),
    v(1,0,1,S,1,1,2'b11,0,8'h10,18'h00000, 1,18'h00AAA, 2),
    v(1,0,1,S,1,1,2'b11,0,8'h12,18'h00000, 1,18'h00CCC, 2),
    v(1,0,1,S,1,1,2'b11,0,8'h13,18'h00000, 1,18'h00567, 13)
  };

  task automatic check(input string rq, input logic drv_e, input logic [DW-1:0] exp);
    n_chk++;
    if (dq_drive !== drv_e || dout !== exp) begin
      n_fail++;
      $display("FAIL %s: drive=%b dout=%05h expected drive=%b dout=%05h",
               rq, dq_drive, dout, drv_e, exp);
    end
  endtask

  task automatic idle();
    start_cpu_n = 1; start_ctl_n = 1; adv_n = 1; ce = S; gwe_n = 1; bwe_n = 1;
    bstb_n = 2'b11; addr = '0; din = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    idle(); lin_order = 0; oe_n = 0; sleep = 0; rst_n = 0;
    repeat (3) @(posedge clk);
    #1 check("R1 in reset", 1'b0, '0);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);
    #1 check("R1 after reset", 1'b0, '0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {start_cpu_n, start_ctl_n, adv_n, ce, gwe_n, bwe_n, bstb_n, lin_order, addr, din}
        = TBL[i][59:23];
      @(posedge clk);
      #1 check($sformatf("R%0d row %0d", TBL[i][3:0], i), TBL[i][22], TBL[i][21:4]);
    end

    // R11: output enable acts without a clock edge
    @(negedge clk); idle(); lin_order = 0;
    oe_n = 1; #0.5 check("R11 oe off", 1'b0, '0);
    oe_n = 0; #0.5 check("R11 oe on", 1'b1, 18'h00567);

    // R12: sleep blocks load and write
    @(negedge clk); sleep = 1; #0.5 check("R12 sleep output off", 1'b0, '0);
    start_ctl_n = 0; addr = 8'h10; gwe_n = 0; din = 18'h3FFFF;
    @(posedge clk); #1 check("R12 asleep edge", 1'b0, '0);
    @(negedge clk); idle(); sleep = 0;
    @(posedge clk); #1 check("R12 state held", 1'b1, 18'h00567);
    @(negedge clk); start_ctl_n = 0; addr = 8'h10;
    @(posedge clk); #1 check("R12 no write in sleep", 1'b1, 18'h00AAA);

    // R10: write then read in the same cycle at a new address
    @(negedge clk); idle(); start_ctl_n = 0; addr = 8'h44; gwe_n = 0; din = 18'h2468A;
    @(posedge clk); #1 check("R10 same-cycle data", 1'b1, 18'h2468A);

    // R1: reset mid-run deselects
    @(negedge clk); idle(); rst_n = 0;
    #0.5 check("R1 async reset", 1'b0, '0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    #1 check("R1 reset release", 1'b0, '0);

    finish_run();
  end

endmodule